// File: doc/BRIEF.md
# Four-Way Age-Counter Replacement Tracker

This block holds the replacement state of a four-way set-associative cache. Every set keeps one 2-bit age per way. An age of 0 marks the most recently used way and an age of 3 marks the least recently used one. The four ages of a set are always the values 0 to 3 in some order, so each set holds a full recency order. Tag storage, data arrays and the path to memory sit outside this block.

Each cycle the cache controller presents a set index. When it also raises the access strobe, it states whether the lookup hit and, on a hit, which way hit. The block shows two results for the addressed set in the same cycle: the way to evict on a miss, and that set's current ages. On the next clock edge it applies the update:

- On a hit, the ways younger than the hit way age by one, and the hit way becomes the youngest.
- On a miss, the evicted way becomes the youngest, and every other way ages by one.

Reset is asynchronous and active low. It is expected to be released synchronously to the clock by the reset logic upstream.

Top module: `lru4_age_tracker`

## Requirements
- R1: After reset, every set holds age w for way w (ages 0, 1, 2, 3 for ways 0 to 3), so the victim of every set is way 3.
- R2: `age_vec_o` shows the ages of the set selected by `acc_set_i`. Bits [2w+1:2w] hold the age of way w. Age 0 means most recently used and age 3 means least recently used.
- R3: A valid hit on way h sets the age of h to 0. It adds one to each way whose age is lower than the old age of h, and leaves every other way unchanged. The new ages are visible from the clock edge that samples the access.
- R4: A valid hit on a way whose age is already 0 leaves all four ages of that set unchanged.
- R5: `victim_way_o` is the way whose age is 3 in the addressed set. It is combinational from the stored ages and the set index, so it follows a change of `acc_set_i` in the same cycle.
- R6: A valid miss sets the victim's age to 0 and adds one to the ages of the other three ways. `acc_way_i` is ignored on a miss.
- R7: Ages change only on a clock edge where `acc_valid_i` is 1. With `acc_valid_i` at 0, the hit flag and way inputs have no effect.
- R8: An access to one set never changes the ages of any other set.
- R9: The four ages of every set always form a permutation of 0 to 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| acc_valid_i | input | 1 | An access is applied at the next clock edge |
| acc_set_i | input | SET_W | Index of the addressed set |
| acc_hit_i | input | 1 | 1 for a hit, 0 for a miss |
| acc_way_i | input | 2 | Hit way; ignored on a miss |
| victim_way_o | output | 2 | Way with age 3 in the addressed set |
| age_vec_o | output | 8 | Ages of the addressed set, 2 bits per way |

## Verification
A wrong age update first shows at the ports the next time the same set is addressed. It shows as a wrong `age_vec_o` and, once the error reaches the oldest position, as a wrong `victim_way_o`. That can be as early as one cycle after the access, or many accesses later if other sets are used in between. A broken write select corrupts a set that was never addressed, and that also stays hidden until the set is read. The stimulus therefore reads sets back directly after each kind of update, and again after long runs spent on other sets. An update that breaks the permutation can leave a set with no age of 3, which leaves the victim undefined. Such faults are caught in the very cycle the damaged set is addressed.

// File: rtl/lru4_pkg.sv
package lru4_pkg;
  localparam int WAYS  = 4;
  localparam int AGE_W = 2;
  localparam int WAY_W = 2;

  typedef logic [AGE_W-1:0] age_t;
  typedef age_t [WAYS-1:0]  ages_t;
  typedef logic [WAY_W-1:0] way_t;

  // Reset order: way w starts with age w.
  function automatic ages_t reset_order();
    ages_t r;
    for (int w = 0; w < WAYS; w++) r[w] = age_t'(w);
    return r;
  endfunction
endpackage

// File: rtl/lru4_victim_pick.sv
module lru4_victim_pick
  import lru4_pkg::*;
(
  input  ages_t ages_i,
  output way_t  victim_o
);
  // Lowest-index way holding the oldest age; a permutation has exactly one.
  always_comb begin
    victim_o = '0;
    for (int w = WAYS-1; w >= 0; w--) begin
      if (ages_i[w] == '1) victim_o = way_t'(w);
    end
  end
endmodule

// File: rtl/lru4_age_update.sv
module lru4_age_update
  import lru4_pkg::*;
(
  input  ages_t cur_i,
  input  logic  hit_i,
  input  way_t  hit_way_i,
  input  way_t  victim_i,
  output ages_t nxt_o
);
  way_t ref_way;
  age_t ref_age;

  assign ref_way = hit_i ? hit_way_i : victim_i;
  assign ref_age = cur_i[ref_way];

  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      if (way_t'(w) == ref_way) begin
        nxt_o[w] = '0;
      end else if (!hit_i) begin
        nxt_o[w] = cur_i[w] + age_t'(1);
      end else if (cur_i[w] < ref_age) begin
        nxt_o[w] = cur_i[w] + age_t'(1);
      end else begin
        nxt_o[w] = cur_i[w];
      end
    end
  end
endmodule

// File: rtl/lru4_age_store.sv
module lru4_age_store
  import lru4_pkg::*;
#(
  parameter int NUM_SETS = 16,
  parameter int SET_W    = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_en_i,
  input  logic [SET_W-1:0]     wr_set_i,
  input  ages_t                wr_ages_i,
  output ages_t [NUM_SETS-1:0] ages_o
);
  for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
    logic  set_en;
    ages_t set_q;

    assign set_en = wr_en_i && (wr_set_i == SET_W'(s));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        set_q <= reset_order();
      end else if (set_en) begin
        set_q <= wr_ages_i;
      end
    end

    assign ages_o[s] = set_q;
  end
endmodule

// File: rtl/lru4_age_tracker.sv
module lru4_age_tracker
  import lru4_pkg::*;
#(
  parameter int NUM_SETS = 16,
  localparam int SET_W   = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   acc_valid_i,
  input  logic [SET_W-1:0]       acc_set_i,
  input  logic                   acc_hit_i,
  input  logic [WAY_W-1:0]       acc_way_i,
  output logic [WAY_W-1:0]       victim_way_o,
  output logic [WAYS*AGE_W-1:0]  age_vec_o
);
  ages_t [NUM_SETS-1:0] set_ages_q;
  ages_t                cur_ages;
  ages_t                nxt_ages;
  way_t                 victim;

  assign cur_ages = set_ages_q[acc_set_i];

  lru4_victim_pick u_pick (
    .ages_i   (cur_ages),
    .victim_o (victim)
  );

  lru4_age_update u_upd (
    .cur_i     (cur_ages),
    .hit_i     (acc_hit_i),
    .hit_way_i (acc_way_i),
    .victim_i  (victim),
    .nxt_o     (nxt_ages)
  );

  lru4_age_store #(
    .NUM_SETS (NUM_SETS),
    .SET_W    (SET_W)
  ) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (acc_valid_i),
    .wr_set_i  (acc_set_i),
    .wr_ages_i (nxt_ages),
    .ages_o    (set_ages_q)
  );

  assign victim_way_o = victim;
  assign age_vec_o    = cur_ages;
endmodule

// File: rtl/lru4_age_chk.sv
module lru4_age_chk
  import lru4_pkg::*;
#(
  parameter int NUM_SETS = 16,
  parameter int SET_W    = 4
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  acc_valid_i,
  input logic [SET_W-1:0]      acc_set_i,
  input logic                  acc_hit_i,
  input logic [WAY_W-1:0]      acc_way_i,
  input logic [WAY_W-1:0]      victim_way_o,
  input logic [WAYS*AGE_W-1:0] age_vec_o,
  input ages_t [NUM_SETS-1:0]  set_ages_q
);
  ages_t seen;
  assign seen = age_vec_o;

  function automatic logic is_perm(ages_t a);
    logic [WAYS-1:0] hit_vals;
    hit_vals = '0;
    for (int w = 0; w < WAYS; w++) hit_vals[a[w]] = 1'b1;
    return hit_vals == '1;
  endfunction

  for (genvar s = 0; s < NUM_SETS; s++) begin : g_chk
    // R9: every set stays a permutation
    a_r9_set_perm: assert property (@(posedge clk_i) disable iff (!rst_ni)
      is_perm(set_ages_q[s]));
    // R8: a set not addressed by a valid access keeps its ages
    a_r8_set_isolated: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(acc_valid_i && acc_set_i == SET_W'(s)) |=> $stable(set_ages_q[s]));
  end

  // R5: the victim is the oldest way of the addressed set
  a_r5_victim_oldest: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen[victim_way_o] == '1);

  // R3: after a hit the hit way is the youngest
  a_r3_hit_youngest: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_i && acc_hit_i) |=>
      (acc_set_i != $past(acc_set_i)) || (seen[$past(acc_way_i)] == '0));

  // R4: a hit on the youngest way changes nothing
  a_r4_mru_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_i && acc_hit_i && seen[acc_way_i] == '0) |=>
      (acc_set_i != $past(acc_set_i)) || (age_vec_o == $past(age_vec_o)));

  // R6: after a miss the evicted way is the youngest
  a_r6_miss_fill: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_i && !acc_hit_i) |=>
      (acc_set_i != $past(acc_set_i)) || (seen[$past(victim_way_o)] == '0));
endmodule

bind lru4_age_tracker lru4_age_chk #(
  .NUM_SETS (NUM_SETS),
  .SET_W    (SET_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .acc_valid_i  (acc_valid_i),
  .acc_set_i    (acc_set_i),
  .acc_hit_i    (acc_hit_i),
  .acc_way_i    (acc_way_i),
  .victim_way_o (victim_way_o),
  .age_vec_o    (age_vec_o),
  .set_ages_q   (set_ages_q)
);

// File: tb/sim_lru4_age_tracker.sv
`timescale 1ns/1ps
module sim_lru4_age_tracker;
  localparam int NSETS  = 16;
  localparam int SW     = 4;
  localparam int PERIOD = 20;

  logic          clk;
  logic          rst_n;
  logic          acc_valid;
  logic [SW-1:0] acc_set;
  logic          acc_hit;
  logic [1:0]    acc_way;
  logic [1:0]    victim;
  logic [7:0]    ages;

  lru4_age_tracker #(.NUM_SETS(NSETS)) u0 (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .acc_valid_i  (acc_valid),
    .acc_set_i    (acc_set),
    .acc_hit_i    (acc_hit),
    .acc_way_i    (acc_way),
    .victim_way_o (victim),
    .age_vec_o    (ages)
  );

  initial clk = 1'b0;
  always #(PERIOD/2) clk = ~clk;

  typedef struct {
    logic [7:0] ages;
    logic [1:0] vic;
    string      tag;
  } item_t;

  item_t      sb_q[$];
  int         n_checks = 0;
  int         n_errors = 0;
  bit         done     = 1'b0;
  logic [1:0] mdl [NSETS][4];

  function automatic int mdl_victim(int s);
    for (int k = 0; k < 4; k++) if (mdl[s][k] == 2'd3) return k;
    return 0;
  endfunction

  function automatic void mdl_update(int s, bit h, int w);
    int rw;
    logic [1:0] ra;
    rw = h ? w : mdl_victim(s);
    ra = mdl[s][rw];
    for (int k = 0; k < 4; k++) begin
      if (k == rw) mdl[s][k] = 2'd0;
      else if (!h || mdl[s][k] < ra) mdl[s][k] = mdl[s][k] + 2'd1;
    end
  endfunction

  // Driver: applies one cycle of stimulus and queues the outputs the
  // requirements predict for that cycle (state before this access).
  task automatic step(bit v, int s, bit h, int w, string tag);
    item_t it;
    @(negedge clk);
    acc_valid = v;
    acc_set   = SW'(s);
    acc_hit   = h;
    acc_way   = 2'(w);
    for (int k = 0; k < 4; k++) it.ages[2*k +: 2] = mdl[s][k];
    it.vic = 2'(mdl_victim(s));
    it.tag = tag;
    sb_q.push_back(it);
    if (v) mdl_update(s, h, w);
  endtask

  // Monitor: compares the outputs mid-cycle against the queued items.
  initial begin
    item_t it;
    logic [3:0] vals;
    forever begin
      @(negedge clk);
      #(PERIOD/4);
      if (sb_q.size() > 0) begin
        it = sb_q.pop_front();
        n_checks++;
        if (ages !== it.ages) begin
          n_errors++;
          $display("FAIL %s/R2 ages: actual %h expected %h", it.tag, ages, it.ages);
        end
        n_checks++;
        if (victim !== it.vic) begin
          n_errors++;
          $display("FAIL %s/R5 victim: actual %0d expected %0d", it.tag, victim, it.vic);
        end
        vals = '0;
        for (int k = 0; k < 4; k++) vals[ages[2*k +: 2]] = 1'b1;
        n_checks++;
        if (vals !== 4'hF) begin
          n_errors++;
          $display("FAIL %s/R9 permutation: actual %h expected a permutation", it.tag, ages);
        end
      end
    end
  end

  initial begin
    #(PERIOD * 100000);
    if (!done) begin
      n_errors++;
      n_checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    acc_valid = 1'b0;
    acc_set   = '0;
    acc_hit   = 1'b0;
    acc_way   = '0;
    for (int s = 0; s < NSETS; s++)
      for (int k = 0; k < 4; k++) mdl[s][k] = 2'(k);
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: reset order in every set
    for (int s = 0; s < NSETS; s++) step(0, s, 0, 0, "R1");

    // R6: miss with a nonsense way value, then read back
    step(1, 0, 0, 1, "R6");
    step(0, 0, 0, 0, "R6");
    step(1, 0, 0, 3, "R6");
    step(0, 0, 0, 0, "R6");

    // R3: hits on ways of middle and oldest age
    step(1, 0, 1, 1, "R3");
    step(0, 0, 0, 0, "R3");
    step(1, 0, 1, mdl_victim(0), "R3");
    step(1, 0, 1, 2, "R3");
    step(0, 0, 0, 0, "R3");

    // R4: hit on the youngest way
    for (int k = 0; k < 4; k++) if (mdl[0][k] == 2'd0) step(1, 0, 1, k, "R4");
    step(0, 0, 0, 0, "R4");

    // R7: strobe low with hit and miss patterns
    step(0, 0, 1, 3, "R7");
    step(0, 0, 0, 2, "R7");
    step(0, 0, 1, 1, "R7");

    // R8: hammer set 5, then read sets 0 and 6
    for (int i = 0; i < 20; i++) step(1, 5, i[0], i % 4, "R8");
    step(0, 0, 0, 0, "R8");
    step(0, 6, 0, 0, "R8");
    step(0, 5, 0, 0, "R8");

    // R5: victim follows set index changes cycle by cycle
    for (int i = 0; i < 6; i++) step(0, (i % 2) ? 5 : 0, 0, 0, "R5");

    // R9: pseudo-random mix over all sets
    lfsr = 16'hACE1;
    for (int i = 0; i < 600; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[8] | lfsr[9], int'(lfsr[3:0]), lfsr[4] | lfsr[5],
           int'(lfsr[7:6]), "R9");
    end
    for (int s = 0; s < NSETS; s++) step(0, s, 0, 0, "R9");

    @(negedge clk);
    acc_valid = 1'b0;
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule